// File: doc/BRIEF.md
# Legacy ROM Shadow Access Router

This block decides, for every processor or bus-master memory access, whether the access goes to main DRAM or to the PCI side where the boot ROM sits. The legacy window from 0xC0000 up to 0xFFFFF is cut into twelve 16 KB segments and one 64 KB top segment. Each segment carries its own pair of attribute bits, so reads and writes to one segment can go to different targets at the same time. Firmware uses this to shadow ROM. During the copy phase, reads are taken from ROM while writes fill DRAM. The segment is then switched so that reads come from DRAM and writes no longer reach it.

The block also guards the system-management memory window at 0xA0000–0xBFFFF. Secondary-bus masters are refused there. The processor reaches that DRAM only while the management-mode flag is raised; otherwise its accesses fall through to PCI. Attribute updates arrive on a simple write port. Each request gets one registered response one cycle later.

Top module: `shadow_router`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `rsp_to_dram`, `rsp_denied` and `rsp_fill_ones` are 0, and every segment attribute is 2'b00.
- R2: Attribute field k (k = 0..11) governs addresses 0xC0000 + k·0x4000 up to 0x3FFF above that. Field 12 governs 0xF0000–0xFFFFF. In each field, bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM. Writing one field leaves every other field unchanged, and writes naming an index of 13 or more are ignored.
- R3: A segment whose attribute is 2'b00 sends both reads and writes to PCI (`rsp_to_dram` = 0).
- R4: A segment whose attribute is 2'b10 (copy phase) sends reads to PCI and writes to DRAM.
- R5: A segment whose attribute is 2'b01 (locked shadow) sends reads to DRAM and writes to PCI, so DRAM is never written.
- R6: A segment whose attribute is 2'b11 sends reads and writes to DRAM.
- R7: A bus-master access (`req_bus_master` = 1) inside 0xA0000–0xBFFFF is denied in any mode. The response has `rsp_denied` = 1 and `rsp_to_dram` = 0. `rsp_fill_ones` = 1 for a read and 0 for a write.
- R8: A processor access inside 0xA0000–0xBFFFF goes to DRAM when `smm_mode` = 1 and to PCI when `smm_mode` = 0. A processor access is never denied.
- R9: An attribute write applies to requests presented in later cycles. A request presented in the same cycle as the write is routed by the old value.
- R10: `rsp_valid` equals `req_valid` of the previous cycle. While `rsp_valid` is 0, all other outputs are 0.
- R11: Addresses outside 0xA0000–0xFFFFF go to DRAM when they are below `DRAM_TOP` (default 0x0800_0000) and to PCI otherwise. They are never denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus_master | input | 1 | 1 = secondary-bus master, 0 = processor |
| smm_mode | input | 1 | Processor is in system-management mode |
| cfg_we | input | 1 | Attribute field write strobe |
| cfg_seg | input | IDX_W | Index of the attribute field written |
| cfg_attr | input | 2 | New attribute: bit 1 write-to-DRAM, bit 0 read-to-DRAM |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_to_dram | output | 1 | 1 = route to DRAM, 0 = route to PCI |
| rsp_denied | output | 1 | Access refused |
| rsp_fill_ones | output | 1 | Denied read must return all-ones data |

## Verification
The assertions assume that each request is a single cycle with address, direction, requester and mode flag stable within that cycle. They also assume that `smm_mode` reflects the processor state, with no meaning attached to it for bus-master requests. The stimulus changes inputs only at the falling edge and holds them for one full cycle. It drives `smm_mode` freely for both requester types so that the denial rule is seen not to depend on it. Random traffic picks among the legacy segments, the management window, low memory and the whole address range. It interleaves attribute writes, including out-of-range indices, with requests in the same cycle.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  // One segment's routing attribute: bit 1 steers writes, bit 0 steers reads.
  typedef struct packed {
    logic wr_dram;
    logic rd_dram;
  } seg_attr_t;

  typedef enum logic {
    RT_PCI  = 1'b0,
    RT_DRAM = 1'b1
  } route_e;

  typedef struct packed {
    logic   valid;
    route_e route;
    logic   denied;
    logic   fill_ones;
  } resp_t;

endpackage

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
  parameter int unsigned           ADDR_W      = 32,
  parameter int unsigned           SMALL_SEGS  = 12,
  parameter int unsigned           SMALL_SHIFT = 14,
  parameter int unsigned           HIGH_SHIFT  = 16,
  parameter int unsigned           SMM_SHIFT   = 17,
  parameter logic [ADDR_W-1:0]     LEGACY_BASE = 'h000C_0000,
  parameter logic [ADDR_W-1:0]     SMM_BASE    = 'h000A_0000,
  localparam int unsigned          NSEG        = SMALL_SEGS + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSEG-1:0]   seg_hit,
  output logic              smm_hit
);

  localparam int unsigned XW = ADDR_W + 1;
  localparam logic [XW-1:0] HIGH_LO =
    {1'b0, LEGACY_BASE} + (XW'(SMALL_SEGS) << SMALL_SHIFT);
  localparam logic [XW-1:0] HIGH_HI  = HIGH_LO + (XW'(1) << HIGH_SHIFT);
  localparam logic [XW-1:0] SMM_LO   = {1'b0, SMM_BASE};
  localparam logic [XW-1:0] SMM_HI   = SMM_LO + (XW'(1) << SMM_SHIFT);

  logic [XW-1:0] addr_x;
  assign addr_x = {1'b0, addr};

  // Equal-sized low segments: one comparator pair each.
  for (genvar g = 0; g < SMALL_SEGS; g++) begin : g_small
    localparam logic [XW-1:0] LO = {1'b0, LEGACY_BASE} + (XW'(g) << SMALL_SHIFT);
    localparam logic [XW-1:0] HI = LO + (XW'(1) << SMALL_SHIFT);
    assign seg_hit[g] = (addr_x >= LO) && (addr_x < HI);
  end

  // Single large top segment.
  assign seg_hit[SMALL_SEGS] = (addr_x >= HIGH_LO) && (addr_x < HIGH_HI);

  assign smm_hit = (addr_x >= SMM_LO) && (addr_x < SMM_HI);

endmodule

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
  import shadow_pkg::*;
#(
  parameter int unsigned NSEG  = 13,
  parameter int unsigned IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_seg,
  input  seg_attr_t             cfg_attr,
  output seg_attr_t [NSEG-1:0]  attr_q
);

  // One field per segment; an index with no field simply matches nothing.
  for (genvar g = 0; g < NSEG; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) begin
        attr_q[g] <= '0;
      end else if (cfg_we && (cfg_seg == IDX_W'(g))) begin
        attr_q[g] <= cfg_attr;
      end
    end
  end

endmodule

// File: rtl/shadow_route_logic.sv
module shadow_route_logic
  import shadow_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       NSEG     = 13,
  parameter logic [ADDR_W-1:0] DRAM_TOP = 'h0800_0000
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NSEG-1:0]      seg_hit,
  input  logic                 smm_hit,
  input  seg_attr_t [NSEG-1:0] attr,
  input  logic                 is_write,
  input  logic                 bus_master,
  input  logic                 smm_mode,
  output route_e               route,
  output logic                 denied
);

  seg_attr_t sel_attr;
  logic      legacy_hit;

  // Segment ranges are disjoint, so an OR-mux selects the single hit field.
  always_comb begin
    sel_attr = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (seg_hit[i]) sel_attr = sel_attr | attr[i];
    end
  end

  assign legacy_hit = |seg_hit;

  always_comb begin
    route  = RT_PCI;
    denied = 1'b0;
    if (smm_hit) begin
      if (bus_master) begin
        denied = 1'b1;
      end else if (smm_mode) begin
        route = RT_DRAM;
      end
    end else if (legacy_hit) begin
      route = (is_write ? sel_attr.wr_dram : sel_attr.rd_dram) ? RT_DRAM : RT_PCI;
    end else begin
      route = (addr < DRAM_TOP) ? RT_DRAM : RT_PCI;
    end
  end

endmodule

// File: rtl/shadow_router.sv
module shadow_router
  import shadow_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       SMALL_SEGS  = 12,
  parameter int unsigned       SMALL_SHIFT = 14,
  parameter int unsigned       HIGH_SHIFT  = 16,
  parameter int unsigned       SMM_SHIFT   = 17,
  parameter logic [ADDR_W-1:0] LEGACY_BASE = 'h000C_0000,
  parameter logic [ADDR_W-1:0] SMM_BASE    = 'h000A_0000,
  parameter logic [ADDR_W-1:0] DRAM_TOP    = 'h0800_0000,
  localparam int unsigned      NSEG        = SMALL_SEGS + 1,
  localparam int unsigned      IDX_W       = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_bus_master,
  input  logic              smm_mode,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_seg,
  input  logic [1:0]        cfg_attr,
  output logic              rsp_valid,
  output logic              rsp_to_dram,
  output logic              rsp_denied,
  output logic              rsp_fill_ones
);

  logic [NSEG-1:0]      seg_hit;
  logic                 smm_hit;
  seg_attr_t [NSEG-1:0] attr_q;
  route_e               route_d;
  logic                 denied_d;
  resp_t                resp_q;

  shadow_seg_decode #(
    .ADDR_W(ADDR_W), .SMALL_SEGS(SMALL_SEGS), .SMALL_SHIFT(SMALL_SHIFT),
    .HIGH_SHIFT(HIGH_SHIFT), .SMM_SHIFT(SMM_SHIFT),
    .LEGACY_BASE(LEGACY_BASE), .SMM_BASE(SMM_BASE)
  ) u_decode (
    .addr    (req_addr),
    .seg_hit (seg_hit),
    .smm_hit (smm_hit)
  );

  shadow_attr_regs #(.NSEG(NSEG), .IDX_W(IDX_W)) u_attr (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_seg  (cfg_seg),
    .cfg_attr (seg_attr_t'(cfg_attr)),
    .attr_q   (attr_q)
  );

  shadow_route_logic #(.ADDR_W(ADDR_W), .NSEG(NSEG), .DRAM_TOP(DRAM_TOP)) u_route (
    .addr       (req_addr),
    .seg_hit    (seg_hit),
    .smm_hit    (smm_hit),
    .attr       (attr_q),
    .is_write   (req_write),
    .bus_master (req_bus_master),
    .smm_mode   (smm_mode),
    .route      (route_d),
    .denied     (denied_d)
  );

  // Registered response; idle cycles carry an all-zero response.
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_q <= '0;
    end else if (req_valid) begin
      resp_q.valid     <= 1'b1;
      resp_q.route     <= route_d;
      resp_q.denied    <= denied_d;
      resp_q.fill_ones <= denied_d && !req_write;
    end else begin
      resp_q <= '0;
    end
  end

  assign rsp_valid     = resp_q.valid;
  assign rsp_to_dram   = (resp_q.route == RT_DRAM);
  assign rsp_denied    = resp_q.denied;
  assign rsp_fill_ones = resp_q.fill_ones;

endmodule

// File: rtl/shadow_router_chk.sv
module shadow_router_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       SMM_SHIFT = 17,
  parameter logic [ADDR_W-1:0] SMM_BASE  = 'h000A_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_bus_master,
  input logic              smm_mode,
  input logic              rsp_valid,
  input logic              rsp_to_dram,
  input logic              rsp_denied,
  input logic              rsp_fill_ones
);

  localparam int unsigned XW = ADDR_W + 1;
  logic in_smm;
  assign in_smm = ({1'b0, req_addr} >= {1'b0, SMM_BASE}) &&
                  ({1'b0, req_addr} <  ({1'b0, SMM_BASE} + (XW'(1) << SMM_SHIFT)));

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_idle_follows_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_to_dram && !rsp_denied && !rsp_fill_ones));
  p_master_smm_denied_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bus_master && in_smm) |=> (rsp_denied && !rsp_to_dram));
  p_fill_read_only_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bus_master && in_smm) |=> (rsp_fill_ones == !$past(req_write)));
  p_cpu_not_denied_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_bus_master) |=> !rsp_denied);
  p_cpu_smm_out_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_bus_master && !smm_mode && in_smm) |=> !rsp_to_dram);
  p_cpu_smm_in_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_bus_master && smm_mode && in_smm) |=> rsp_to_dram);

endmodule

bind shadow_router shadow_router_chk #(
  .ADDR_W(ADDR_W), .SMM_SHIFT(SMM_SHIFT), .SMM_BASE(SMM_BASE)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .req_write      (req_write),
  .req_bus_master (req_bus_master),
  .smm_mode       (smm_mode),
  .rsp_valid      (rsp_valid),
  .rsp_to_dram    (rsp_to_dram),
  .rsp_denied     (rsp_denied),
  .rsp_fill_ones  (rsp_fill_ones)
);

// File: tb/shadow_router_tb_top.sv
`timescale 1ns/100ps
module shadow_router_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_bus_master = 1'b0;
  logic        smm_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_seg = '0;
  logic [1:0]  cfg_attr = '0;
  logic        rsp_valid, rsp_to_dram, rsp_denied, rsp_fill_ones;

  always #2.5 clk = ~clk;

  shadow_router dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_bus_master(req_bus_master), .smm_mode(smm_mode),
    .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_attr(cfg_attr),
    .rsp_valid(rsp_valid), .rsp_to_dram(rsp_to_dram),
    .rsp_denied(rsp_denied), .rsp_fill_ones(rsp_fill_ones)
  );

  typedef struct {
    bit    v, dram, den, fill;
    string tag;
  } exp_t;

  exp_t expq[$];
  int   model_attr[13];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  task automatic cmp(input bit v, dram, den, fill, input string tag);
    n_cmp++;
    if ({rsp_valid, rsp_to_dram, rsp_denied, rsp_fill_ones} !== {v, dram, den, fill}) begin
      n_bad++;
      $display("FAIL %s: got v/dram/den/fill=%b%b%b%b expected %b%b%b%b",
               tag, rsp_valid, rsp_to_dram, rsp_denied, rsp_fill_ones, v, dram, den, fill);
    end
  endtask

  // Behavioural expectation straight from the requirement list.
  function automatic exp_t predict(bit v, logic [31:0] a, bit w, bit bm, bit sm);
    exp_t e;
    int   idx, at;
    e.v = v; e.dram = 0; e.den = 0; e.fill = 0;
    if (!v) begin e.tag = "R10"; return e; end
    if (a >= 32'hA0000 && a < 32'hC0000) begin
      if (bm) begin e.den = 1; e.fill = !w; e.tag = "R7"; end
      else begin e.dram = sm; e.tag = "R8"; end
    end else if (a >= 32'hC0000 && a < 32'h100000) begin
      idx = (a >= 32'hF0000) ? 12 : int'((a - 32'hC0000) / 32'h4000);
      at  = model_attr[idx];
      e.dram = w ? at[1] : at[0];
      case (at)
        0: e.tag = "R3";
        2: e.tag = "R4";
        1: e.tag = "R5";
        default: e.tag = "R6";
      endcase
    end else begin
      e.dram = (a < 32'h0800_0000);
      e.tag  = "R11";
    end
    return e;
  endfunction

  task automatic step(input bit v, input logic [31:0] a, input bit w, bm, sm,
                      input bit cwe, input logic [3:0] cs, input logic [1:0] ca,
                      input string tag);
    exp_t e;
    if (expq.size() > 0) begin
      e = expq.pop_front();
      cmp(e.v, e.dram, e.den, e.fill, e.tag);
    end
    req_valid = v; req_addr = a; req_write = w; req_bus_master = bm; smm_mode = sm;
    cfg_we = cwe; cfg_seg = cs; cfg_attr = ca;
    e = predict(v, a, w, bm, sm);
    if (tag != "") e.tag = tag;
    expq.push_back(e);
    if (cwe && cs < 13) model_attr[cs] = int'(ca);
    @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input string tag = "");
    step(1, a, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [31:0] a, input string tag = "");
    step(1, a, 1, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic setattr(input int s, input logic [1:0] at);
    step(0, 0, 0, 0, 0, 1, 4'(s), at, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (model_attr[i]) model_attr[i] = 0;
    repeat (3) @(negedge clk);
    cmp(0, 0, 0, 0, "R1 reset");
    rst = 1'b0;
    // R1: attributes reset to 00, so legacy reads go to PCI
    rd(32'hC0000, "R1");
    rd(32'hF8000, "R1");
    // R9: write copy attribute with a same-cycle read, then read again
    step(1, 32'hCC010, 0, 0, 0, 1, 4'd3, 2'b10, "R9 old");
    rd(32'hCC010, "R4");
    wr(32'hCFFFC, "R4");
    // R5: locked
    setattr(3, 2'b01);
    rd(32'hCC000, "R5");
    wr(32'hCC000, "R5");
    // R2: neighbours untouched
    rd(32'hC8000, "R2");
    rd(32'hD0000, "R2");
    setattr(3, 2'b11);
    rd(32'hCC000, "R6");
    wr(32'hCC000, "R6");
    setattr(3, 2'b00);
    wr(32'hCC000, "R3");
    // R2: top segment versus the last small one
    setattr(12, 2'b01);
    rd(32'hFFFF0, "R2");
    rd(32'hEC000, "R2");
    setattr(11, 2'b10);
    wr(32'hEFFFF, "R2");
    step(0, 0, 0, 0, 0, 1, 4'd13, 2'b11, "");
    rd(32'hC0000, "R2 oob");
    // R7 / R8 management window
    step(1, 32'hA0000, 0, 1, 1, 0, 0, 0, "R7");
    step(1, 32'hBFFFF, 1, 1, 0, 0, 0, 0, "R7");
    step(1, 32'hA8000, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 32'hA8000, 1, 0, 0, 0, 0, 0, "R8");
    // R11 outside
    rd(32'h0010_0000, "R11");
    rd(32'h0800_0000, "R11");
    rd(32'h0009_FFFF, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // Random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] a;
      case ($urandom % 4)
        0: a = 32'hC0000 + ($urandom % 32'h40000);
        1: a = 32'hA0000 + ($urandom % 32'h20000);
        2: a = $urandom % 32'hA0000;
        default: a = $urandom;
      endcase
      step(($urandom % 5) != 0, a, $urandom % 2, $urandom % 2, $urandom % 2,
           ($urandom % 4) == 0, 4'($urandom % 16), 2'($urandom % 4), "");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule